// File: doc/BRIEF.md
# Divide-by-N Word Timing Generator with Follower Alignment

This block produces the word-rate timing for a parallel-to-serial video multiplexer. It runs entirely on the fast bit clock. A phase counter steps through the n bit slots of each word, where n is 8 or 10. From that counter the block derives three outputs: a word clock at the bit rate divided by n, a one-cycle strobe that marks each word boundary, and the current phase value.

Several serializers can be made to shift in lockstep. Each follower instance has its alignment input tied to the word clock of one leader instance, or to a common word-rate clock that is phase-locked to the bit clock. In follower mode, a rising edge on the alignment input pulls the phase counter back to zero. An alignment flag reports that the phase has stayed put for twice the word length.

The length select is taken only at a word boundary, so a word is never cut short. A free-running leader ignores its alignment input.

Top module: `mtg_timing_gen`

## Requirements
- R1: While reset is asserted, and directly after it, `phase` is 0, `word_strobe` is 0, `locked` is 0 and `slow_clk` is 1. The word length after reset is 8.
- R2: `phase` counts up by one on each clock and returns to 0 after reaching n-1. n is 8 when the active length select is 0 and 10 when it is 1.
- R3: `len_sel` is sampled only on the clock edge at which `phase` goes from n-1 to 0. The new length applies from the word that starts at that edge. A change of `len_sel` at any other phase does not alter the length of the current word.
- R4: `word_strobe` is 1 in exactly those cycles in which `phase` has just wrapped naturally from n-1 to 0, and 0 in all other cycles.
- R5: `slow_clk` is 1 when `phase` is below floor(n/2) and 0 otherwise.
- R6: With `follow_en` = 1, a 0-to-1 transition of `align_in` forces `phase` to 0. Take the clock edge that first samples `align_in` high. `phase` reads 0 after the third clock edge counted from, and including, that edge.
- R7: With `follow_en` = 0, `align_in` has no effect on `phase` or `locked`.
- R8: `locked` goes to 1 once 2n clock edges have passed since reset or since the last misaligned edge. A misaligned edge is one that forces `phase` to 0 while `phase` was not at n-1. A misaligned edge clears `locked` on the same clock.
- R9: A periodic `align_in` at the word rate, whose detected rising edges land where `phase` is n-1, keeps `locked` at 1 once it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_sel | input | 1 | Word length select: 0 selects 8, 1 selects 10 |
| align_in | input | 1 | Alignment input, asynchronous to the block |
| follow_en | input | 1 | 1 = follow `align_in`, 0 = free-run and ignore it |
| slow_clk | output | 1 | Word clock, bit rate / n |
| word_strobe | output | 1 | One-cycle pulse at each natural word boundary |
| phase | output | 4 | Current bit slot in the word |
| locked | output | 1 | Phase has been stable for at least 2n cycles |

## Verification
The assertions assume that `len_sel` and `follow_en` change only between clock edges. They also assume that `align_in` is low before its first rise, so that the synchronizer does not report a rise out of reset. The bench drives every input at the falling clock edge. It holds `align_in` low until a rise is wanted. Its periodic alignment pattern runs at exactly the word rate, which keeps the follower-lock property within the case it describes.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

  typedef enum logic {
    TM_FREE   = 1'b0,
    TM_FOLLOW = 1'b1
  } timing_mode_e;

  // word length for the active select
  function automatic int unsigned word_len(input logic sel,
                                           input int unsigned len_a,
                                           input int unsigned len_b);
    return sel ? len_b : len_a;
  endfunction

  // number of high cycles of the word clock
  function automatic int unsigned high_len(input int unsigned n);
    return n / 2;
  endfunction

  // cycles without disturbance needed to report alignment
  function automatic int unsigned lock_len(input int unsigned n);
    return 2 * n;
  endfunction

endpackage

// File: rtl/mtg_sync_edge.sv
module mtg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] meta_q;
  logic              prev_q;
  logic              sampled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= {meta_q[STAGES-2:0], async_i};
      prev_q <= meta_q[STAGES-1];
    end
  end

  assign sampled = meta_q[STAGES-1];
  assign rise_o  = sampled & ~prev_q;

  // a detected rise lasts exactly one cycle
  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/mtg_phase_ctr.sv
module mtg_phase_ctr
  import mtg_pkg::*;
#(
  parameter int LEN_A = 8,
  parameter int LEN_B = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_sel_i,
  input  logic             force_zero_i,
  output logic [CNT_W-1:0] phase_o,
  output logic             mode_o,
  output logic             wrap_o,
  output logic             slow_clk_o,
  output logic             strobe_o
);
  logic [CNT_W-1:0] phase_q, phase_d;
  logic             mode_q, mode_d;
  logic             slow_q, slow_d;
  logic             strobe_q;
  int unsigned      n_cur, n_next;
  logic             at_last;

  always_comb begin
    n_cur   = word_len(mode_q, LEN_A, LEN_B);
    at_last = (32'(phase_q) == n_cur - 1);
    mode_d  = at_last ? len_sel_i : mode_q;
    n_next  = word_len(mode_d, LEN_A, LEN_B);
    if (force_zero_i || at_last) phase_d = '0;
    else                         phase_d = phase_q + 1'b1;
    slow_d  = (32'(phase_d) < high_len(n_next));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      mode_q   <= 1'b0;
      slow_q   <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      mode_q   <= mode_d;
      slow_q   <= slow_d;
      strobe_q <= at_last;
    end
  end

  assign phase_o    = phase_q;
  assign mode_o     = mode_q;
  assign wrap_o     = at_last;
  assign slow_clk_o = slow_q;
  assign strobe_o   = strobe_q;

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_q) < word_len(mode_q, LEN_A, LEN_B));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> $stable(mode_q));

  assert_strobe_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (strobe_q && phase_q == '0));

  assert_strobe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> !strobe_q);

  assert_slow_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slow_q == (32'(phase_q) < high_len(word_len(mode_q, LEN_A, LEN_B))));

  assert_force_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero_i |=> phase_q == '0);

endmodule

// File: rtl/mtg_lock_mon.sv
module mtg_lock_mon
  import mtg_pkg::*;
#(
  parameter int LEN_A  = 8,
  parameter int LEN_B  = 10,
  parameter int LCNT_W = 5,
  parameter int SAT    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic misalign_i,
  input  logic mode_i,
  output logic locked_o
);
  logic [LCNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (misalign_i)                 cnt_d = '0;
    else if (32'(cnt_q) < SAT)      cnt_d = cnt_q + 1'b1;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign locked_o = (32'(cnt_q) >= lock_len(word_len(mode_i, LEN_A, LEN_B)));

  assert_clear_on_misalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_i |=> !locked_o);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !misalign_i) |=> (locked_o || !$stable(mode_i)));

endmodule

// File: rtl/mtg_timing_gen.sv
module mtg_timing_gen
  import mtg_pkg::*;
#(
  parameter int LEN_A       = 8,
  parameter int LEN_B       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_MAX    = (LEN_A > LEN_B) ? LEN_A : LEN_B,
  localparam int CNT_W      = $clog2(LEN_MAX),
  localparam int LOCK_SAT   = 2 * LEN_MAX,
  localparam int LCNT_W     = $clog2(LOCK_SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_sel,
  input  logic             align_in,
  input  logic             follow_en,
  output logic             slow_clk,
  output logic             word_strobe,
  output logic [CNT_W-1:0] phase,
  output logic             locked
);
  // named internal events
  logic         align_rise;
  logic         at_wrap;
  logic         cur_mode;
  logic         force_zero;
  logic         misalign;
  timing_mode_e tmode;

  assign tmode      = timing_mode_e'(follow_en);
  assign force_zero = (tmode == TM_FOLLOW) && align_rise;
  assign misalign   = force_zero && !at_wrap;

  mtg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(align_in),
    .rise_o (align_rise)
  );

  mtg_phase_ctr #(.LEN_A(LEN_A), .LEN_B(LEN_B), .CNT_W(CNT_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_sel_i   (len_sel),
    .force_zero_i(force_zero),
    .phase_o     (phase),
    .mode_o      (cur_mode),
    .wrap_o      (at_wrap),
    .slow_clk_o  (slow_clk),
    .strobe_o    (word_strobe)
  );

  mtg_lock_mon #(.LEN_A(LEN_A), .LEN_B(LEN_B), .LCNT_W(LCNT_W), .SAT(LOCK_SAT)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .misalign_i(misalign),
    .mode_i    (cur_mode),
    .locked_o  (locked)
  );

  // free-running: the count advances regardless of align_in
  assert_free_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow_en && at_wrap) |=> phase == '0);

  assert_free_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow_en && !at_wrap) |=> phase == $past(phase) + 1'b1);

endmodule

// File: tb/mtg_timing_gen_tb.sv
module mtg_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       len_sel = 1'b0;
  logic       align_in = 1'b0;
  logic       follow_en = 1'b0;
  logic       slow_clk, word_strobe, locked;
  logic [3:0] phase;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit model_on = 0;

  // behavioural model state
  int m_phase = 0, m_mode = 0, m_cnt = 0, m_strobe = 0;
  int sq[$] = '{0, 0, 0}; // synchronizer history: [0] newest

  always #(CLK_PERIOD/2) clk = ~clk;

  mtg_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .align_in(align_in),
    .follow_en(follow_en), .slow_clk(slow_clk), .word_strobe(word_strobe),
    .phase(phase), .locked(locked)
  );

  function automatic int nlen(int m);
    return (m != 0) ? 10 : 8;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mode = 0; m_cnt = 0; m_strobe = 0;
      sq = '{0, 0, 0};
    end else begin
      automatic int n = nlen(m_mode);
      automatic bit rise = (sq[1] == 1) && (sq[2] == 0);
      automatic bit last = (m_phase == n - 1);
      automatic bit pull = follow_en && rise;
      m_strobe = last;
      if (last) m_mode = len_sel;
      if (pull || last) m_phase = 0; else m_phase++;
      if (pull && !last) m_cnt = 0; else if (m_cnt < 20) m_cnt++;
      sq.push_front(int'(align_in));
      void'(sq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      automatic int n = nlen(m_mode);
      check(phase == m_phase, "R2 phase", phase, m_phase);
      check(word_strobe == m_strobe, "R4 strobe", word_strobe, m_strobe);
      check(slow_clk == (m_phase < n / 2), "R5 slow_clk", slow_clk, int'(m_phase < n / 2));
      check(locked == (m_cnt >= 2 * n), "R8 locked", locked, int'(m_cnt >= 2 * n));
    end
  end

  task automatic step(input int k = 1);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_phase(input int p);
    for (int i = 0; i < 40; i++) begin
      if (phase == p) return;
      step();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int k;
    int per;
    bit held;
    step(3);
    // R1: reset values
    check(phase == 0, "R1 phase", phase, 0);
    check(word_strobe == 0, "R1 strobe", word_strobe, 0);
    check(locked == 0, "R1 locked", locked, 0);
    check(slow_clk == 1, "R1 slow_clk", slow_clk, 1);
    model_on = 1;
    rst_n = 1'b1;

    // R8: lock from reset after 2*8 edges
    k = 0;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (locked) begin k = i; break; end
    end
    check(k == 16, "R8 lock time", k, 16);

    // R3: length change only at the boundary
    wait_phase(3);
    len_sel = 1'b1;
    for (int i = 0; i < 20; i++) begin if (word_strobe) break; step(); end
    per = 0;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (i == 2) len_sel = 1'b0;
      if (word_strobe) begin per = i; break; end
    end
    check(per == 10, "R3 word length 10", per, 10);
    per = 0;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (word_strobe) begin per = i; break; end
    end
    check(per == 8, "R3 word length back to 8", per, 8);

    // R7: free-running ignores align_in
    follow_en = 1'b0;
    wait_phase(4);
    align_in = 1'b1;
    step(5);
    check(phase == 1, "R7 phase unaffected", phase, 1);
    check(locked == 1, "R7 lock unaffected", locked, 1);
    align_in = 1'b0;
    step(4);

    // R6: misaligned rise in follower mode
    follow_en = 1'b1;
    wait_phase(4);
    align_in = 1'b1;
    step(2);
    check(phase == 6, "R6 phase before pull", phase, 6);
    step();
    check(phase == 0, "R6 phase pulled to 0", phase, 0);
    check(locked == 0, "R8 cleared by misaligned edge", locked, 0);
    step(6);
    align_in = 1'b0;
    step(10);

    // R9: periodic word-rate alignment keeps lock
    held = 1;
    for (int i = 0; i < 120; i++) begin
      align_in = ((i % 8) < 4);
      step();
      if (i >= 40 && !locked) held = 0;
    end
    check(held == 1, "R9 lock held with periodic align", int'(held), 1);
    check(locked == 1, "R9 locked at end", locked, 1);
    align_in = 1'b0;
    step(10);
    finish_run();
  end

endmodule